// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block decides which clock source drives the core after reset and after each wake from sleep. Software picks a source through a two-bit select register. A configured primary-oscillator mode says whether the external source is a crystal that needs time to settle. Two enable bits, one for the internal/external switchover and one for fail-safe operation, allow the fast start. The block counts synchronised edge strobes from the external oscillator. When a crystal mode is configured and the fast start is allowed, the core runs from the internal oscillator until 1024 such edges have been seen. It then moves to the primary source and raises a settle-done flag.

The block never writes to the software select register on its own. A switch it makes by itself is visible only on the one-hot source outputs and the status flags. Entering sleep abandons a count in progress, and every wake starts counting again from zero. The glitch-free multiplexer that acts on the one-hot select lives outside this block, as do the oscillators themselves.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: Reset (active-low `rstN`) clears the select register `srcSelQ` to 00 and clears `ostDone`.
- R2: Select register encodings: 01 selects the secondary oscillator. 10 and 11 select the internal oscillator. 00 defers to the configured primary mode. The register loads `srcSelWrData` on a clock edge where `srcSelWrEn` is high.
- R3: With select 00, a crystal primary mode and fast start allowed, `selInternal` is asserted while `ostDone` is low. `selPrimary` is asserted once `ostDone` is high.
- R4: `ostDone` is set on the clock edge that samples the 1024th `extEdge` strobe after the count is armed. Strobes beyond that leave it set, and the edge counter saturates rather than wrapping.
- R5: The fast start is allowed when `ieso` or `failSafeEn` is high. With both low, select 00 and a crystal mode give `selPrimary` even while counting.
- R6: `primaryMode` 0, 1 and 2 are the crystal modes; 3 to 7 are non-crystal. In a non-crystal mode no strobes are needed. `ostDone` is set one clock after arming, and select 00 always gives `selPrimary`.
- R7: `sleepReq` high clears the edge count and `ostDone` on the next clock edge. Lowering it re-arms the count from zero.
- R8: An automatic move between internal and primary sources leaves `srcSelQ` unchanged.
- R9: Exactly one of `selPrimary`, `selInternal`, `selSecondary` is high at all times. `intRunning` and `secRunning` report the internal and secondary selections.
- R10: After reset the count is armed only once `porDone` is high. Strobes seen before that are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| porDone | input | 1 | Power-up delay finished |
| sleepReq | input | 1 | High while the device sleeps |
| extEdge | input | 1 | One-cycle strobe per external oscillator cycle, already synchronised |
| primaryMode | input | 3 | Configured primary oscillator mode (0..2 crystal) |
| ieso | input | 1 | Internal/external switchover enable |
| failSafeEn | input | 1 | Fail-safe enable, also allows the fast start |
| srcSelWrEn | input | 1 | Write strobe for the select register |
| srcSelWrData | input | 2 | Value written to the select register |
| srcSelQ | output | 2 | Current software select value |
| selPrimary | output | 1 | Primary source selected |
| selInternal | output | 1 | Internal oscillator selected |
| selSecondary | output | 1 | Secondary oscillator selected |
| intRunning | output | 1 | Status: core on internal oscillator |
| secRunning | output | 1 | Status: core on secondary oscillator |
| ostDone | output | 1 | Status: external settle count complete |

## Verification
The hardest case is a sleep that arrives after most of the count, followed by a wake. If the counter were not cleared, the flag would rise far too early after the wake, and this can only be seen by counting strobes precisely on both sides of the sleep. The bench drives 700 strobes, sleeps, wakes, and then drives exactly 1023 strobes. It checks that the flag is still low, then that one further strobe sets it. The same exact-count method is used after power-up, where strobes sent before `porDone` must be ignored.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2,
    ST_SLEEP = 2'd3
  } tscState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic doneSet;
    logic doneClr;
  } tscCtl_s;

  localparam logic [1:0] SRC_CFG = 2'b00;
  localparam logic [1:0] SRC_SEC = 2'b01;

  function automatic logic isCrystal(input logic [2:0] mode);
    return mode <= 3'd2;
  endfunction

endpackage

// File: rtl/tsc_control.sv
module tsc_control
  import tsc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      porDone,
  input  logic      sleepReq,
  input  logic      extEdge,
  input  logic      crystal,
  input  logic      lastEdge,
  output tscCtl_s   ctl,
  output tscState_e state
);

  tscState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    unique case (state)
      ST_WAIT: begin
        ctl.cntClr = 1'b1;
        if (porDone) nextState = sleepReq ? ST_SLEEP : ST_COUNT;
      end
      ST_COUNT: begin
        if (sleepReq) begin
          ctl.cntClr  = 1'b1;
          ctl.doneClr = 1'b1;
          nextState   = ST_SLEEP;
        end else if (!crystal) begin
          ctl.doneSet = 1'b1;
          nextState   = ST_READY;
        end else if (extEdge) begin
          ctl.cntInc = 1'b1;
          if (lastEdge) begin
            ctl.doneSet = 1'b1;
            nextState   = ST_READY;
          end
        end
      end
      ST_READY: begin
        if (sleepReq) begin
          ctl.cntClr  = 1'b1;
          ctl.doneClr = 1'b1;
          nextState   = ST_SLEEP;
        end else if (extEdge) begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_SLEEP: begin
        ctl.cntClr  = 1'b1;
        ctl.doneClr = 1'b1;
        if (!sleepReq) nextState = ST_COUNT;
      end
      default: nextState = ST_WAIT;
    endcase
  end

  AST_WAIT_FOR_POR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !porDone) |=> (state == ST_WAIT)); // R10

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_WAIT && sleepReq) |=> (state == ST_SLEEP)); // R7

  AST_WAKE_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !sleepReq) |=> (state == ST_COUNT)); // R7

endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int OST_EDGES = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  tscCtl_s    ctl,
  input  logic       srcSelWrEn,
  input  logic [1:0] srcSelWrData,
  input  logic [2:0] primaryMode,
  input  logic       ieso,
  input  logic       failSafeEn,
  output logic [1:0] srcSelQ,
  output logic       lastEdge,
  output logic       doneQ,
  output logic       selPrimary,
  output logic       selInternal,
  output logic       selSecondary
);

  localparam int CNT_W = $clog2(OST_EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(OST_EDGES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OST_EDGES - 1);

  logic [CNT_W-1:0] edgeCnt;
  logic             crystal;
  logic             fastStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           srcSelQ <= SRC_CFG;
    else if (srcSelWrEn) srcSelQ <= srcSelWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  edgeCnt <= '0;
    else if (ctl.cntClr)                        edgeCnt <= '0;
    else if (ctl.cntInc && edgeCnt != CNT_MAX)  edgeCnt <= edgeCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            doneQ <= 1'b0;
    else if (ctl.doneClr) doneQ <= 1'b0;
    else if (ctl.doneSet) doneQ <= 1'b1;
  end

  assign lastEdge  = (edgeCnt == CNT_LAST);
  assign crystal   = isCrystal(primaryMode);
  assign fastStart = (ieso || failSafeEn) && crystal;

  always_comb begin
    selPrimary   = 1'b0;
    selInternal  = 1'b0;
    selSecondary = 1'b0;
    if (srcSelQ == SRC_SEC)                selSecondary = 1'b1;
    else if (srcSelQ != SRC_CFG)           selInternal  = 1'b1;
    else if (fastStart && !doneQ)          selInternal  = 1'b1;
    else                                   selPrimary   = 1'b1;
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({selPrimary, selInternal, selSecondary}) == 1); // R9

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= CNT_MAX); // R4

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !srcSelWrEn |=> $stable(srcSelQ)); // R8

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneQ) && $past(crystal)) |-> ($past(edgeCnt) == CNT_LAST)); // R4

  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doneClr |=> (!doneQ && edgeCnt == '0)); // R7

endmodule

// File: rtl/twospeed_clk_ctrl.sv
module twospeed_clk_ctrl
  import tsc_pkg::*;
#(
  parameter int OST_EDGES = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porDone,
  input  logic       sleepReq,
  input  logic       extEdge,
  input  logic [2:0] primaryMode,
  input  logic       ieso,
  input  logic       failSafeEn,
  input  logic       srcSelWrEn,
  input  logic [1:0] srcSelWrData,
  output logic [1:0] srcSelQ,
  output logic       selPrimary,
  output logic       selInternal,
  output logic       selSecondary,
  output logic       intRunning,
  output logic       secRunning,
  output logic       ostDone
);

  tscCtl_s   ctl;
  tscState_e state;
  logic      lastEdge;
  logic      crystal;

  assign crystal = isCrystal(primaryMode);

  tsc_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .porDone  (porDone),
    .sleepReq (sleepReq),
    .extEdge  (extEdge),
    .crystal  (crystal),
    .lastEdge (lastEdge),
    .ctl      (ctl),
    .state    (state)
  );

  tsc_datapath #(.OST_EDGES(OST_EDGES)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .srcSelWrEn   (srcSelWrEn),
    .srcSelWrData (srcSelWrData),
    .primaryMode  (primaryMode),
    .ieso         (ieso),
    .failSafeEn   (failSafeEn),
    .srcSelQ      (srcSelQ),
    .lastEdge     (lastEdge),
    .doneQ        (ostDone),
    .selPrimary   (selPrimary),
    .selInternal  (selInternal),
    .selSecondary (selSecondary)
  );

  assign intRunning = selInternal;
  assign secRunning = selSecondary;

endmodule

// File: tb/twospeed_clk_ctrl_tb.sv
`timescale 1ns/1ps
module twospeed_clk_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       porDone = 1'b0;
  logic       sleepReq = 1'b0;
  logic       extEdge = 1'b0;
  logic [2:0] primaryMode = 3'd1;
  logic       ieso = 1'b1;
  logic       failSafeEn = 1'b0;
  logic       srcSelWrEn = 1'b0;
  logic [1:0] srcSelWrData = 2'b00;
  logic [1:0] srcSelQ;
  logic       selPrimary, selInternal, selSecondary;
  logic       intRunning, secRunning, ostDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twospeed_clk_ctrl dut_i (
    .clk(clk), .rstN(rstN), .porDone(porDone), .sleepReq(sleepReq),
    .extEdge(extEdge), .primaryMode(primaryMode), .ieso(ieso),
    .failSafeEn(failSafeEn), .srcSelWrEn(srcSelWrEn),
    .srcSelWrData(srcSelWrData), .srcSelQ(srcSelQ),
    .selPrimary(selPrimary), .selInternal(selInternal),
    .selSecondary(selSecondary), .intRunning(intRunning),
    .secRunning(secRunning), .ostDone(ostDone)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // sel vector packed as {secondary, internal, primary}
  task automatic checkSel(input string req, input logic [2:0] exp);
    check(req, "select", {29'd0, selSecondary, selInternal, selPrimary}, {29'd0, exp});
    check("R9", "status", {30'd0, secRunning, intRunning}, {30'd0, exp[2], exp[1]});
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) extEdge = 1'b1;
    end
    @(negedge clk) extEdge = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    porDone = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeSel(input logic [1:0] v);
    @(negedge clk) begin srcSelWrEn = 1'b1; srcSelWrData = v; end
    @(negedge clk) srcSelWrEn = 1'b0;
  endtask

  task automatic enterSleep();
    @(negedge clk) sleepReq = 1'b1;
    @(negedge clk);
  endtask

  task automatic wake();
    @(negedge clk) sleepReq = 1'b0;
  endtask

  task automatic t_powerUp();
    doReset();
    check("R1", "srcSelQ after reset", {30'd0, srcSelQ}, 32'd0);
    check("R1", "ostDone after reset", {31'd0, ostDone}, 32'd0);
    pulses(1100);
    check("R10", "no count before porDone", {31'd0, ostDone}, 32'd0);
    @(negedge clk) porDone = 1'b1;
    pulses(1023);
    check("R4", "1023 edges not enough", {31'd0, ostDone}, 32'd0);
    checkSel("R3", 3'b010);
    pulses(1);
    check("R4", "1024th edge sets done", {31'd0, ostDone}, 32'd1);
    checkSel("R3", 3'b001);
    check("R8", "select unchanged by switch", {30'd0, srcSelQ}, 32'd0);
    pulses(20);
    check("R4", "done held when saturated", {31'd0, ostDone}, 32'd1);
  endtask

  task automatic t_sleepAbort();
    pulses(5);
    enterSleep();
    check("R7", "sleep clears done", {31'd0, ostDone}, 32'd0);
    checkSel("R7", 3'b010);
    wake();
    pulses(700);
    enterSleep();
    wake();
    pulses(1023);
    check("R7", "count restarted after sleep", {31'd0, ostDone}, 32'd0);
    pulses(1);
    check("R7", "done after full recount", {31'd0, ostDone}, 32'd1);
    check("R8", "select still 00", {30'd0, srcSelQ}, 32'd0);
  endtask

  task automatic t_enables();
    enterSleep();
    ieso = 1'b0; failSafeEn = 1'b0;
    wake();
    pulses(100);
    checkSel("R5", 3'b001);
    failSafeEn = 1'b1;
    @(negedge clk);
    checkSel("R5", 3'b010);
    pulses(924);
    check("R5", "fail-safe start completes", {31'd0, ostDone}, 32'd1);
    ieso = 1'b1; failSafeEn = 1'b0;
  endtask

  task automatic t_selects();
    writeSel(2'b01);
    checkSel("R2", 3'b100);
    writeSel(2'b10);
    checkSel("R2", 3'b010);
    writeSel(2'b11);
    checkSel("R2", 3'b010);
    check("R2", "srcSelQ readback", {30'd0, srcSelQ}, 32'd3);
    enterSleep();
    wake();
    pulses(1024);
    check("R8", "select kept across auto count", {30'd0, srcSelQ}, 32'd3);
    writeSel(2'b00);
    checkSel("R2", 3'b001);
  endtask

  task automatic t_nonCrystal();
    enterSleep();
    primaryMode = 3'd5;
    @(negedge clk);
    checkSel("R6", 3'b001);
    wake();
    @(negedge clk);
    check("R6", "not yet done at arm", {31'd0, ostDone}, 32'd0);
    @(negedge clk);
    check("R6", "bypass sets done", {31'd0, ostDone}, 32'd1);
    checkSel("R6", 3'b001);
    primaryMode = 3'd1;
  endtask

  task automatic t_resetClears();
    writeSel(2'b10);
    doReset();
    check("R1", "reset clears select", {30'd0, srcSelQ}, 32'd0);
    check("R1", "reset clears done", {31'd0, ostDone}, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_powerUp();
    t_sleepAbort();
    t_enables();
    t_selects();
    t_nonCrystal();
    t_resetClears();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule